// File: doc/BRIEF.md
# Flash fault address capture register

This block holds the double-word address of the first flash access that went wrong, together with a bit that says whether that address lies in the main array or in the shadow array. Three error sources report to it through strobes, and any of them may fire in the same cycle as the others:

- an uncorrectable ECC event,
- a single-bit correction,
- a failed program/erase state-machine operation.

Each strobe carries the failing double-word address and a space bit. The block picks one source by fixed priority and latches its address. It also keeps the sticky status flag that belongs to each source.

Software reaches the block through a simple register port with two registers. The address register shows the captured address. Software may load it, unless one of the ECC flags is set. The status register holds the two ECC flags, which are cleared by writing 1, and a pass flag for the state machine, which reads 1 while the last operation is good. A test enable freezes hardware capture so that software can load an address of its own, for example to exercise the ECC checking path.

Top module: `flash_fault_addr_cap`

## Requirements
- R1: After reset the address field and space bit read 0, the uncorrectable flag (status bit 0) reads 0, the correction flag (status bit 1) reads 0, and the pass flag (status bit 2) reads 1.
- R2: Register select 0 reads the address register: bit 31 is the space bit (0 main, 1 shadow), bits [20:3] are the stored double-word address, and every other bit is 0. Register select 1 reads the status register: bit 0 uncorrectable, bit 1 correction, bit 2 pass, and every other bit 0.
- R3: When several sources report in one cycle and capture is allowed, the uncorrectable event's address and space bit are stored. Without an uncorrectable event, a correction wins over a state-machine failure.
- R4: Each flag follows its own source:
  - an uncorrectable strobe sets status bit 0 on the next cycle;
  - a correction strobe sets status bit 1 on the next cycle;
  - a state-machine failure clears status bit 2;
  - a state-machine start sets status bit 2, and a failure in the same cycle as a start takes precedence.
- R5: While status bit 0 or bit 1 is set, no error source changes the address or the space bit. Only the first ECC-class failure is kept until both flags are cleared.
- R6: A software write to the address register is ignored while status bit 0 or bit 1 is set. A cleared pass flag does not block the write.
- R7: A software write never changes the space bit. Bit 31 of the write data is ignored.
- R8: While the test enable is 1, no error source updates the address or the space bit. The flags still respond to their sources, and software writes to the address register behave as in R6.
- R9: Writing status with bit 0 or bit 1 set to 1 clears that flag. A strobe setting the flag in the same cycle wins over the clear. Write-data bit 2 has no effect on the pass flag.
- R10: A hardware capture and a software address write in the same cycle store the hardware address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | ECC logic-check test enable; freezes hardware capture |
| ded_vld | input | 1 | Uncorrectable ECC event strobe |
| ded_addr | input | 18 | Uncorrectable event double-word address (bits [20:3]) |
| ded_shadow | input | 1 | Uncorrectable event space bit |
| sbc_vld | input | 1 | Single-bit correction strobe |
| sbc_addr | input | 18 | Correction double-word address |
| sbc_shadow | input | 1 | Correction space bit |
| sm_fail | input | 1 | State-machine operation failure strobe |
| sm_addr | input | 18 | State-machine failure double-word address |
| sm_shadow | input | 1 | State-machine failure space bit |
| sm_start | input | 1 | New state-machine operation started |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 address, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected register |

## Verification
The bench aims at cycles where all three sources fire together. A wrong priority order would store the correction or the state-machine address instead of the uncorrectable one. It also hits a locked address with later strobes and with software writes, which would show an overwritten first failure if the lock were missing or driven from the pass flag. Same-cycle set-and-clear of a flag and same-cycle hardware-and-software updates are driven on purpose: a design with the wrong winner would lose a flag or latch the software value. Test mode is run with live strobes, so an address that moves while frozen is caught, and so is a flag that fails to set.

// File: rtl/flash_fault_addr_cap.sv
module flash_fault_addr_cap #(
  parameter int AW   = 21,
  parameter int LSB  = 3,
  parameter int DW   = 32,
  parameter int QPOS = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              test_en,
  input  logic              ded_vld,
  input  logic [AW-1:LSB]   ded_addr,
  input  logic              ded_shadow,
  input  logic              sbc_vld,
  input  logic [AW-1:LSB]   sbc_addr,
  input  logic              sbc_shadow,
  input  logic              sm_fail,
  input  logic [AW-1:LSB]   sm_addr,
  input  logic              sm_shadow,
  input  logic              sm_start,
  input  logic              reg_wr_en,
  input  logic              reg_sel,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata
);
  localparam int FW = AW - LSB;

  logic [FW-1:0] addr_q;
  logic          shad_q;
  logic          eer_q, sbc_q, peg_q;

  logic          locked, hw_ok, hw_cap, sw_wr, st_wr;
  logic [FW-1:0] hw_addr;
  logic          hw_shad;

  assign locked = eer_q | sbc_q;
  assign hw_ok  = ~test_en & ~locked;
  assign hw_cap = hw_ok & (ded_vld | sbc_vld | sm_fail);
  assign sw_wr  = reg_wr_en & ~reg_sel & ~locked;
  assign st_wr  = reg_wr_en & reg_sel;

  always_comb begin
    if (ded_vld) begin
      hw_addr = ded_addr;
      hw_shad = ded_shadow;
    end else if (sbc_vld) begin
      hw_addr = sbc_addr;
      hw_shad = sbc_shadow;
    end else begin
      hw_addr = sm_addr;
      hw_shad = sm_shadow;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      shad_q <= 1'b0;
    end else if (hw_cap) begin
      addr_q <= hw_addr;
      shad_q <= hw_shad;
    end else if (sw_wr) begin
      addr_q <= reg_wdata[AW-1:LSB];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eer_q <= 1'b0;
      sbc_q <= 1'b0;
      peg_q <= 1'b1;
    end else begin
      eer_q <= (eer_q & ~(st_wr & reg_wdata[0])) | ded_vld;
      sbc_q <= (sbc_q & ~(st_wr & reg_wdata[1])) | sbc_vld;
      if (sm_fail)       peg_q <= 1'b0;
      else if (sm_start) peg_q <= 1'b1;
    end
  end

  logic [DW-1:0] addr_view, stat_view;
  always_comb begin
    addr_view             = '0;
    addr_view[AW-1:LSB]   = addr_q;
    addr_view[QPOS]       = shad_q;
    stat_view             = '0;
    stat_view[2:0]        = {peg_q, sbc_q, eer_q};
  end

  assign reg_rdata = reg_sel ? stat_view : addr_view;

  logic unused_wbits;
  assign unused_wbits = ^{reg_wdata[DW-1:AW], reg_wdata[LSB-1:2]};
endmodule

module flash_fault_addr_cap_chk #(
  parameter int FW = 18
) (
  input logic          clk,
  input logic          rst_n,
  input logic          test_en,
  input logic          ded_vld,
  input logic [FW-1:0] ded_addr,
  input logic          sbc_vld,
  input logic          sm_fail,
  input logic          sm_start,
  input logic          reg_wr_en,
  input logic          reg_sel,
  input logic [FW-1:0] addr_q,
  input logic          shad_q,
  input logic          eer_q,
  input logic          sbc_q,
  input logic          peg_q
);
  a_r5_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (eer_q || sbc_q) |=> ($stable(addr_q) && $stable(shad_q)));

  a_r8_test_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (test_en && !(reg_wr_en && !reg_sel)) |=> ($stable(addr_q) && $stable(shad_q)));

  a_r4_eer_set: assert property (@(posedge clk) disable iff (!rst_n)
    ded_vld |=> eer_q);

  a_r4_sbc_set: assert property (@(posedge clk) disable iff (!rst_n)
    sbc_vld |=> sbc_q);

  a_r4_peg_fail: assert property (@(posedge clk) disable iff (!rst_n)
    sm_fail |=> !peg_q);

  a_r4_peg_start: assert property (@(posedge clk) disable iff (!rst_n)
    (sm_start && !sm_fail) |=> peg_q);

  a_r3_ded_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (ded_vld && !test_en && !eer_q && !sbc_q) |=> (addr_q == $past(ded_addr)));
endmodule

bind flash_fault_addr_cap flash_fault_addr_cap_chk #(.FW(FW)) u_chk (
  .clk(clk), .rst_n(rst_n), .test_en(test_en), .ded_vld(ded_vld),
  .ded_addr(ded_addr), .sbc_vld(sbc_vld), .sm_fail(sm_fail),
  .sm_start(sm_start), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
  .addr_q(addr_q), .shad_q(shad_q), .eer_q(eer_q), .sbc_q(sbc_q),
  .peg_q(peg_q)
);

// File: tb/tb_flash_fault_addr_cap.sv
module tb_flash_fault_addr_cap;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        test_en = 0, ded_vld = 0, ded_shadow = 0, sbc_vld = 0, sbc_shadow = 0;
  logic        sm_fail = 0, sm_shadow = 0, sm_start = 0, reg_wr_en = 0, reg_sel = 0;
  logic [17:0] ded_addr = 0, sbc_addr = 0, sm_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;

  int checks = 0, fails = 0;
  bit done = 0;

  int m_addr = 0;
  bit m_shad = 0, m_eer = 0, m_sbc = 0, m_peg = 1;

  always #10 clk = ~clk;

  flash_fault_addr_cap dut (
    .clk(clk), .rst_n(rst_n), .test_en(test_en),
    .ded_vld(ded_vld), .ded_addr(ded_addr), .ded_shadow(ded_shadow),
    .sbc_vld(sbc_vld), .sbc_addr(sbc_addr), .sbc_shadow(sbc_shadow),
    .sm_fail(sm_fail), .sm_addr(sm_addr), .sm_shadow(sm_shadow),
    .sm_start(sm_start), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_addr();
    logic [31:0] v = 0;
    v[20:3] = m_addr[17:0];
    v[31]   = m_shad;
    return v;
  endfunction

  function automatic logic [31:0] exp_stat();
    return {29'd0, m_peg, m_sbc, m_eer};
  endfunction

  task automatic compare(input string req);
    reg_sel = 1'b0; #1;
    chk(req, reg_rdata, exp_addr());
    reg_sel = 1'b1; #1;
    chk(req, reg_rdata, exp_stat());
  endtask

  task automatic step(input string req);
    bit lock = m_eer || m_sbc;
    bit hw = !test_en && !lock;
    bit stw = reg_wr_en && reg_sel;
    if (hw && ded_vld) begin m_addr = ded_addr; m_shad = ded_shadow; end
    else if (hw && sbc_vld) begin m_addr = sbc_addr; m_shad = sbc_shadow; end
    else if (hw && sm_fail) begin m_addr = sm_addr; m_shad = sm_shadow; end
    else if (reg_wr_en && !reg_sel && !lock) m_addr = reg_wdata[20:3];
    m_eer = (m_eer && !(stw && reg_wdata[0])) || ded_vld;
    m_sbc = (m_sbc && !(stw && reg_wdata[1])) || sbc_vld;
    if (sm_fail) m_peg = 0;
    else if (sm_start) m_peg = 1;
    @(posedge clk); #2;
    {ded_vld, sbc_vld, sm_fail, sm_start, reg_wr_en} = '0;
    compare(req);
    @(negedge clk);
  endtask

  task automatic sw_write(input bit sel, input logic [31:0] d);
    reg_wr_en = 1; reg_sel = sel; reg_wdata = d;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1; @(negedge clk);
    compare("R1");

    // R4, R2: state-machine failure sets address and clears pass
    sm_fail = 1; sm_addr = 18'h2ABCD; sm_shadow = 1; step("R4");
    // R6, R7: write allowed with pass low; space bit untouched
    sw_write(0, 32'h0001_2340 | 32'h8000_0007); step("R7");
    // R4: start restores pass, fail wins over start
    sm_start = 1; step("R4");
    sm_start = 1; sm_fail = 1; sm_addr = 18'h00011; sm_shadow = 0; step("R4");
    // R3: all three together
    ded_vld = 1; ded_addr = 18'h15555; ded_shadow = 1;
    sbc_vld = 1; sbc_addr = 18'h0AAAA; sbc_shadow = 0;
    sm_fail = 1; sm_addr = 18'h3FFFF; sm_shadow = 0; step("R3");
    // R5: later strobes ignored
    ded_vld = 1; ded_addr = 18'h00001; ded_shadow = 0; step("R5");
    sm_fail = 1; sm_addr = 18'h00002; step("R5");
    // R6: software write ignored while locked
    sw_write(0, 32'h001F_FFF8); step("R6");
    // R9: clear one flag, still locked; bit 2 ignored
    sw_write(1, 32'h0000_0005); step("R9");
    sbc_vld = 1; sbc_addr = 18'h01234; step("R5");
    sw_write(1, 32'h0000_0002); step("R9");
    // R3: correction beats state machine
    sbc_vld = 1; sbc_addr = 18'h2468A; sbc_shadow = 1;
    sm_fail = 1; sm_addr = 18'h13579; sm_shadow = 0; step("R3");
    // R9: set wins over clear in the same cycle
    sw_write(1, 32'h0000_0003); sbc_vld = 1; sbc_addr = 18'h0; step("R9");
    sw_write(1, 32'h0000_0003); step("R9");
    // R8: test mode, software load allowed, hardware frozen, flags set
    test_en = 1;
    sw_write(0, 32'h0012_3458); step("R8");
    ded_vld = 1; ded_addr = 18'h3C3C3; ded_shadow = 0; step("R8");
    sw_write(1, 32'h0000_0001); step("R8");
    sm_fail = 1; sm_addr = 18'h11111; step("R8");
    test_en = 0;
    // R10: hardware beats software in the same cycle
    sm_fail = 1; sm_addr = 18'h0F0F0; sm_shadow = 1;
    sw_write(0, 32'h0007_7770); step("R10");
    sm_start = 1; step("R4");

    for (int i = 0; i < 400; i++) begin
      test_en    = ($urandom_range(0, 7) == 0);
      ded_vld    = ($urandom_range(0, 9) == 0);
      sbc_vld    = ($urandom_range(0, 6) == 0);
      sm_fail    = ($urandom_range(0, 5) == 0);
      sm_start   = ($urandom_range(0, 4) == 0);
      ded_addr   = 18'($urandom); sbc_addr = 18'($urandom); sm_addr = 18'($urandom);
      ded_shadow = 1'($urandom); sbc_shadow = 1'($urandom); sm_shadow = 1'($urandom);
      if ($urandom_range(0, 2) == 0) sw_write(1'($urandom), $urandom);
      step("R5");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule